// File: doc/BRIEF.md
# Ping-Pong Capture Buffer with Overrun Detection

This block takes a stream of packed 32-bit sample words and writes them into two on-chip RAM banks of 256 words each. It fills one bank completely and then hands that bank to the host for draining. While the host reads it out, the block fills the other bank. The host reads through a simple address/data port and then signals that it has finished with the bank. Every completed fill swaps the roles of the two banks.

The host drains the banks in the order they were filled. A status bit says that a full bank is waiting. An index bit says which bank that is. A one-cycle done pulse returns the bank to the writer.

The writer may reach the end of a bank and move on to a bank the host has not yet returned. In that case the block raises a sticky overrun flag and counts the event. It keeps writing into that bank anyway, so the captured record has a gap but the input is never stalled. Buffer logic and host port share one clock.

Top module: `pp_capture_top`

## Requirements
- R1: After a synchronous active-low reset, both banks are free (`ready`=0), writing starts at bank 0 address 0 (`fill_bank`=0), `ready_bank`=0, the overrun flag is 0 and the overrun count is 0.
- R2: The k-th accepted word of a fill (k = 0..255) is stored at address k of the bank being filled. A read address presented on `rd_addr` returns that word on `rd_data` one clock later, from the bank shown by `ready_bank`.
- R3: On the clock edge that accepts the 256th word of a fill, the bank becomes full and `fill_bank` toggles to the other bank. From the next cycle, `ready` is 1 and `ready_bank` names the oldest full bank.
- R4: A cycle with `in_valid` low writes nothing and does not advance the write address or the bank.
- R5: A `drained` pulse while `ready` is 1 frees the bank named by `ready_bank` and toggles `ready_bank`. `ready` then reflects whether that other bank is full.
- R6: A `drained` pulse while `ready` is 0 has no effect on `ready` or `ready_bank`.
- R7: When a fill completes and the next bank is still full, `ovr_flag` is set and `ovr_count` increments on the following cycle. Writing continues and overwrites that bank from address 0.
- R8: `ovr_flag` stays set until an `ovr_clr` pulse or a reset. When `ovr_clr` arrives in the same cycle as a new overrun, the flag stays set.
- R9: `ovr_count` saturates at its maximum value. It is not cleared by `ovr_clr`, only by reset.
- R10: When a `drained` pulse frees the very bank that the writer enters in the same cycle, no overrun is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Buffer and host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample word present this cycle |
| in_word | input | DW (32) | Packed sample word |
| fill_bank | output | 1 | Bank currently being written |
| rd_addr | input | AW (8) | Host read address within the drain bank |
| rd_data | output | DW (32) | Read word, one cycle after `rd_addr` |
| ready | output | 1 | A full bank awaits draining |
| ready_bank | output | 1 | Index of the bank to drain |
| drained | input | 1 | One-cycle pulse: host has finished the drain bank |
| ovr_clr | input | 1 | One-cycle pulse: clear the overrun flag |
| ovr_flag | output | 1 | Sticky overrun indicator |
| ovr_count | output | CNT_W (16) | Saturating count of overrun events |

## Verification
The word stream is written both with `in_valid` held high and with idle gaps. Comparing the read-back data with the expected sequence shows whether idle cycles advance the address. One drain-and-release cycle that keeps pace with the writer is compared against a host that falls two fills behind. Only the late host should raise the overrun, and the words written afterwards must be seen overwriting the stale bank. A release landing in the exact cycle the writer wraps, and a clear landing on the cycle of a new overrun, separate the two priority rules. A run of nine overruns against a three-bit counter shows saturation.

// File: rtl/pp_pkg.sv
// Shared types for the ping-pong capture buffer.
// Assumes exactly two banks, so a bank index is one bit.
package pp_pkg;
    typedef logic bank_t;

    // Fill completion event raised by the writer
    typedef struct packed {
        logic  done;   // last address of a bank written this cycle
        bank_t bank;   // bank that just became full
    } fill_evt_t;
endpackage

// File: rtl/pp_bank_mem.sv
// One RAM bank: synchronous write port and registered read port.
// Assumes one write and one read per cycle; a read of an address written
// in the same cycle returns the old contents.
module pp_bank_mem #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store an incoming word
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/pp_writer.sv
// Write pointer: steps the address on each accepted word and moves to the
// other bank after the last address. Emits a fill event in that cycle.
// Assumes an input word is accepted every cycle in_valid is high.
module pp_writer
    import pp_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic [AW-1:0] waddr,
    output bank_t         wbank,
    output fill_evt_t     evt
);
    logic last;

    // Detect the final word of the current bank
    always_comb begin
        last      = in_valid && (waddr == {AW{1'b1}});
        evt.done  = last;
        evt.bank  = wbank;
    end

    // Advance address and bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waddr <= '0;
            wbank <= 1'b0;
        end else if (in_valid) begin
            waddr <= waddr + 1'b1;
            if (last) wbank <= ~wbank;
        end
    end
endmodule

// File: rtl/pp_ctrl.sv
// Bank ownership and overrun tracking. Holds a full bit per bank, the
// drain pointer, the sticky overrun flag and a saturating event counter.
// Assumes drained and clr are single-cycle pulses from the host.
module pp_ctrl
    import pp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fill_evt_t        evt,
    input  logic             drained,
    input  logic             clr,
    output logic [1:0]       full,
    output bank_t            dptr,
    output logic             ovr_flag,
    output logic [CNT_W-1:0] ovr_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic       rel_eff;
    logic       ovr_hit;
    bank_t      next_bank;
    logic [1:0] full_n;

    // Decide release, overrun and next ownership state
    always_comb begin
        rel_eff   = drained && full[dptr];
        next_bank = ~evt.bank;
        ovr_hit   = evt.done && full[next_bank] &&
                    !(rel_eff && (dptr == next_bank));
        full_n    = full;
        if (rel_eff)  full_n[dptr]     = 1'b0;
        if (evt.done) full_n[evt.bank] = 1'b1;
    end

    // Ownership registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 2'b00;
            dptr <= 1'b0;
        end else begin
            full <= full_n;
            if (rel_eff) dptr <= ~dptr;
        end
    end

    // Sticky overrun flag, set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n)       ovr_flag <= 1'b0;
        else if (ovr_hit) ovr_flag <= 1'b1;
        else if (clr)     ovr_flag <= 1'b0;
    end

    // Saturating overrun counter
    always_ff @(posedge clk) begin
        if (!rst_n)                             ovr_count <= '0;
        else if (ovr_hit && ovr_count != CNT_MAX) ovr_count <= ovr_count + 1'b1;
    end
endmodule

// File: rtl/pp_capture_top.sv
// Ping-pong capture buffer top. Two RAM banks are filled alternately from
// the sample stream; the host drains the oldest full bank and releases it.
// Assumes host port and stream share clk.
module pp_capture_top
    import pp_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_word,
    output logic             fill_bank,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic             ready,
    output logic             ready_bank,
    input  logic             drained,
    input  logic             ovr_clr,
    output logic             ovr_flag,
    output logic [CNT_W-1:0] ovr_count
);
    localparam int NBANK = 2;

    logic [AW-1:0] waddr;
    bank_t         wbank;
    fill_evt_t     evt;
    logic [1:0]    full;
    bank_t         dptr;
    bank_t         rsel_q;
    logic [DW-1:0] bank_rd [NBANK];

    pp_writer #(.AW(AW)) u_wr (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .waddr(waddr), .wbank(wbank), .evt(evt)
    );

    pp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .evt(evt), .drained(drained),
        .clr(ovr_clr), .full(full), .dptr(dptr),
        .ovr_flag(ovr_flag), .ovr_count(ovr_count)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        pp_bank_mem #(.DW(DW), .AW(AW)) u_mem (
            .clk(clk),
            .we(in_valid && (wbank == bank_t'(g))),
            .waddr(waddr), .wdata(in_word),
            .raddr(rd_addr), .rdata(bank_rd[g])
        );
    end

    // Remember which bank the read was issued to
    always_ff @(posedge clk) begin
        if (!rst_n) rsel_q <= 1'b0;
        else        rsel_q <= dptr;
    end

    // Output steering
    always_comb begin
        rd_data    = bank_rd[rsel_q];
        fill_bank  = wbank;
        ready      = full[dptr];
        ready_bank = dptr;
    end
endmodule

// File: rtl/pp_capture_chk.sv
// Port-level protocol checks for pp_capture_top, attached by bind.
module pp_capture_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             fill_bank,
    input logic             ready,
    input logic             ready_bank,
    input logic             drained,
    input logic             ovr_clr,
    input logic             ovr_flag,
    input logic [CNT_W-1:0] ovr_count
);
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(fill_bank));

    // R5
    release_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && drained) |=> (ready_bank != $past(ready_bank)));

    // R6
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && drained) |=> $stable(ready_bank));

    // R8
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clr) |=> ovr_flag);

    // R9
    count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ovr_count >= $past(ovr_count)));

    // R7
    flag_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> ((ovr_count != $past(ovr_count)) || (&ovr_count)));
endmodule

bind pp_capture_top pp_capture_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fill_bank(fill_bank),
    .ready(ready), .ready_bank(ready_bank), .drained(drained),
    .ovr_clr(ovr_clr), .ovr_flag(ovr_flag), .ovr_count(ovr_count)
);

// File: tb/sim_pp_capture_top.sv
module sim_pp_capture_top;
    localparam int CLK_PERIOD = 14;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam int CW = 3;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_word = '0;
    logic          fill_bank;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          ready, ready_bank;
    logic          drained = 1'b0;
    logic          ovr_clr = 1'b0;
    logic          ovr_flag;
    logic [CW-1:0] ovr_count;

    int tests = 0;
    int fails = 0;
    logic [DW-1:0] model [2][DEPTH];
    int m_bank = 0;
    int m_addr = 0;
    logic [DW-1:0] expq [$];
    logic rd_req = 1'b0;
    logic rd_req_d = 1'b0;
    bit done = 0;

    pp_capture_top #(.DW(DW), .AW(AW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .fill_bank(fill_bank), .rd_addr(rd_addr), .rd_data(rd_data),
        .ready(ready), .ready_bank(ready_bank), .drained(drained),
        .ovr_clr(ovr_clr), .ovr_flag(ovr_flag), .ovr_count(ovr_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Monitor: pop expected read data and compare
    always @(posedge clk) rd_req_d <= rd_req;
    always @(negedge clk) begin
        if (rd_req_d) begin
            logic [DW-1:0] e;
            e = expq.pop_front();
            chk(rd_data == e, "R2 read data", rd_data, e);
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_bank = 0;
        m_addr = 0;
    endtask

    // Driver: one word, optional release/clear in the same cycle
    task automatic put_word(input logic [DW-1:0] w, input bit rel, input bit clr);
        in_valid = 1'b1;
        in_word  = w;
        drained  = rel;
        ovr_clr  = clr;
        model[m_bank][m_addr] = w;
        m_addr++;
        if (m_addr == DEPTH) begin
            m_addr = 0;
            m_bank ^= 1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        drained  = 1'b0;
        ovr_clr  = 1'b0;
    endtask

    task automatic put_n(input int n, input logic [DW-1:0] base);
        for (int i = 0; i < n; i++) put_word(base + DW'(i * 32'h01010101), 0, 0);
    endtask

    // Read every word of a bank, pushing expected values
    task automatic drain(input int b);
        for (int i = 0; i < DEPTH; i++) begin
            rd_addr = AW'(i);
            rd_req  = 1'b1;
            expq.push_back(model[b][i]);
            @(negedge clk);
        end
        rd_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_rel();
        drained = 1'b1;
        @(negedge clk);
        drained = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk(ready == 0, "R1 ready", ready, 0);
        chk(fill_bank == 0, "R1 fill_bank", fill_bank, 0);
        chk(ready_bank == 0, "R1 ready_bank", ready_bank, 0);
        chk(ovr_flag == 0, "R1 ovr_flag", ovr_flag, 0);
        chk(ovr_count == 0, "R1 ovr_count", ovr_count, 0);

        // R4 gaps in the stream
        put_n(100, 32'hA000_0000);
        repeat (5) @(negedge clk);
        chk(fill_bank == 0 && ready == 0, "R4 idle holds", {fill_bank, ready}, 0);
        for (int i = 0; i < 156; i++) begin
            put_word(32'hB000_0000 + i, 0, 0);
            @(negedge clk);
        end
        // R3 bank 0 full
        chk(ready == 1, "R3 ready", ready, 1);
        chk(ready_bank == 0, "R3 ready_bank", ready_bank, 0);
        chk(fill_bank == 1, "R3 fill_bank", fill_bank, 1);

        // R2 drain, R5 release
        drain(0);
        pulse_rel();
        chk(ready == 0, "R5 ready after release", ready, 0);
        chk(ready_bank == 1, "R5 ready_bank toggled", ready_bank, 1);

        // R6 release with nothing ready
        pulse_rel();
        chk(ready == 0 && ready_bank == 1, "R6 ignored release", {ready, ready_bank}, 1);

        // R7 host falls behind
        put_n(256, 32'hC000_0000);
        chk(ready == 1 && ready_bank == 1, "R3 bank1 full", {ready, ready_bank}, 3);
        chk(ovr_flag == 0, "R7 no overrun yet", ovr_flag, 0);
        put_n(256, 32'hD000_0000);
        chk(ovr_flag == 1, "R7 overrun flag", ovr_flag, 1);
        chk(ovr_count == 1, "R7 overrun count", ovr_count, 1);
        chk(fill_bank == 1, "R7 writer on stale bank", fill_bank, 1);
        put_n(10, 32'hE000_0000);
        drain(1);
        pulse_rel();
        chk(ready == 1 && ready_bank == 0, "R5 next full bank", {ready, ready_bank}, 2);
        drain(0);
        pulse_rel();
        chk(ready == 0 && ready_bank == 1, "R5 all free", {ready, ready_bank}, 1);

        // R8 clear, R9 count kept
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        chk(ovr_flag == 0, "R8 clear", ovr_flag, 0);
        chk(ovr_count == 1, "R9 count survives clear", ovr_count, 1);

        // R10 release in the wrap cycle
        put_n(246, 32'hF000_0000);
        chk(ready == 1 && ready_bank == 1, "R3 bank1 full again", {ready, ready_bank}, 3);
        put_n(255, 32'h1000_0000);
        put_word(32'h2000_0000, 1, 0);
        chk(ovr_flag == 0, "R10 no overrun", ovr_flag, 0);
        chk(ovr_count == 1, "R10 count unchanged", ovr_count, 1);
        chk(ready == 1 && ready_bank == 0, "R10 bank0 ready", {ready, ready_bank}, 2);
        drain(0);

        // R9 saturation, R8 set beats clear
        do_reset();
        chk(ready == 0 && ovr_count == 0, "R1 reset again", {ready, ovr_count}, 0);
        put_n(9 * 256 + 255, 32'h3000_0000);
        put_word(32'h4000_0000, 0, 1);
        chk(ovr_count == 7, "R9 saturated", ovr_count, 7);
        chk(ovr_flag == 1, "R8 set wins over clear", ovr_flag, 1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        chk(ovr_flag == 0, "R8 cleared", ovr_flag, 0);
        chk(ovr_count == 7, "R9 count held", ovr_count, 7);

        repeat (3) @(negedge clk);
        summary();
    end
endmodule